// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator Stream

This block turns the single-bit output of a second-order delta-sigma modulator into signed 16-bit words. One modulator bit enters on every clock. A high bit counts as +1 and a low bit as -1. Three cascaded accumulators run at the bit rate. Three cascaded first differences run once per output word. Together they form a moving-sum filter of order three.

A rate-select input picks between two decimation ratios. In fast mode the block produces one word every `DEC_FAST` bits. In slow mode the ratio doubles, so one word comes every `2*DEC_FAST` bits. The fast result is rescaled so that both modes share the same full scale.

Each word appears together with a one-clock valid strobe. The first two words after any restart are held back, because the filter needs three word periods to settle. A restart is either a reset or a change of the rate input.

Top module: `sinc3_decim`

## Requirements
- R1: Each bit is taken as +1 when high and -1 when low. The word finished after the n-th bit since a restart is built from the raw sum S. S weights bit n-1-j by the number of ways j can be written as a+b+c with a, b and c each in 0..N-1. Bits from before the restart count as zero.
- R2: With `rate_sel`=1 (fast) a word completes after every `DEC_FAST` integrated bits. With `rate_sel`=0 (slow) it completes after every `2*DEC_FAST` bits.
- R3: `dout_valid` is high for exactly one clock, in the cycle after the clock edge that integrated the last bit of a word. It is low in every other cycle.
- R4: After a restart, the first and second words raise no `dout_valid`. Every word from the third onwards raises it.
- R5: Suppose a clock edge sees `rate_sel` differ from the rate in use. On that edge all filter state, the bit count, the settling count and `dout` are cleared. The bit sampled on that edge is discarded, and the new rate is adopted. After reset the rate in use is fast.
- R6: While `rst_n` is low, `dout` is 0 and `dout_valid` is 0.
- R7: `dout` is the low 16 bits of (S*8 in fast mode, S in slow mode), arithmetically shifted right by `ACC_W-16`. That is one place with the default parameters. An all-high stream settles to +16384 and an all-low stream settles to -16384 in both modes.
- R8: `dout` changes only on an edge that completes a word or on a restart. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 1 = fast (ratio `DEC_FAST`), 0 = slow (ratio `2*DEC_FAST`) |
| mod_bit | input | 1 | One-bit modulator sample, taken on every rising edge |
| dout | output | 16 | Signed filtered word |
| dout_valid | output | 1 | One-clock strobe marking a settled word |

## Verification
Several rules are checked on every cycle by the assertions:
- the strobe is a single-cycle pulse that follows a word boundary;
- the strobe stays off until three word boundaries have passed since a restart;
- a restart clears the output;
- `dout` holds between boundaries;
- word boundaries are spaced by one of the two ratios;
- settled words stay inside the normalised full scale.

Other properties can only be shown by the bench's scenarios, which compare each word against an independently computed weighted sum. These are the exact value of each word, the transient shape of the first words after a restart, and the rescaling of fast mode against slow mode. The same holds for where a mid-word rate change lands in the bit stream.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  localparam int SINC_ORDER = 3;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  // A modulator bit as a signed unit step.
  function automatic int bit_to_step(input logic b);
    return b ? 1 : -1;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
`timescale 1ns/1ps
module sinc3_integ #(
  parameter int ACC_W = 17,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    sample_bit,
  output logic signed [ACC_W-1:0] acc_next
);
  import sinc3_pkg::*;

  logic signed [ACC_W-1:0] acc_q   [ORDER];
  logic signed [ACC_W-1:0] acc_sum [ORDER];
  logic signed [ACC_W-1:0] step_ext;

  assign step_ext = ACC_W'(bit_to_step(sample_bit));

  // Combinational cascade: each stage sees this cycle's new value of the
  // previous stage, so the chain is a pure 1/(1-z^-1)^ORDER with no delay.
  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign acc_sum[s] = acc_q[s] + step_ext;
    end else begin : g_next
      assign acc_sum[s] = acc_q[s] + acc_sum[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q[s] <= '0;
      else if (clear) acc_q[s] <= '0;
      else            acc_q[s] <= acc_sum[s];
    end
  end

  assign acc_next = acc_sum[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
module sinc3_comb #(
  parameter int ACC_W = 17,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    tick,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] diff_out
);
  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [ACC_W-1:0] diff  [ORDER];
  logic signed [ACC_W-1:0] stage_in [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_in[s] = din;
    end else begin : g_next
      assign stage_in[s] = diff[s-1];
    end

    assign diff[s] = stage_in[s] - dly_q[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dly_q[s] <= '0;
      else if (clear) dly_q[s] <= '0;
      else if (tick)  dly_q[s] <= stage_in[s];
    end
  end

  assign diff_out = diff[ORDER-1];
endmodule

// File: rtl/sinc3_ctrl.sv
`timescale 1ns/1ps
module sinc3_ctrl #(
  parameter int N_FAST = 16,
  parameter int N_SLOW = 32,
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic restart,
  output logic word_tick,
  output logic settled,
  output logic fast_mode
);
  import sinc3_pkg::*;

  localparam int CNT_W = $clog2(N_SLOW);
  localparam int WC_W  = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(N_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(N_SLOW - 1);
  localparam logic [WC_W-1:0]  WC_TOP    = WC_W'(SETTLE - 1);

  rate_e            rate_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] bit_last;
  logic [WC_W-1:0]  word_cnt;

  assign fast_mode = (rate_q == RATE_FAST);
  assign restart   = (rate_e'(rate_sel) != rate_q);
  assign bit_last  = fast_mode ? LAST_FAST : LAST_SLOW;
  assign word_tick = !restart && (bit_cnt == bit_last);
  assign settled   = (word_cnt == WC_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= RATE_FAST;
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else if (restart) begin
      rate_q   <= rate_e'(rate_sel);
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else if (word_tick) begin
      bit_cnt <= '0;
      if (!settled) word_cnt <= word_cnt + 1'b1;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim #(
  parameter int DEC_FAST = 16,
  parameter int OUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rate_sel,
  input  logic                    mod_bit,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dout_valid
);
  import sinc3_pkg::*;

  localparam int DEC_SLOW = 2 * DEC_FAST;
  localparam int ORDER    = SINC_ORDER;
  localparam int ACC_W    = ORDER * $clog2(DEC_SLOW) + 2;
  localparam int GAIN_SH  = ORDER;
  localparam int EXT_W    = ACC_W + OUT_W + GAIN_SH;
  localparam int DROP     = (ACC_W > OUT_W) ? (ACC_W - OUT_W) : 0;
  localparam int LIFT     = (OUT_W > ACC_W) ? (OUT_W - ACC_W) : 0;

  // Bring the raw sum to a common full scale and cut it to OUT_W bits.
  function automatic logic signed [OUT_W-1:0] scale_word(
    input logic signed [ACC_W-1:0] raw,
    input logic                    fast
  );
    logic signed [EXT_W-1:0] ext;
    ext = EXT_W'(raw);
    if (fast) ext = ext <<< GAIN_SH;
    ext = (ext >>> DROP) <<< LIFT;
    return ext[OUT_W-1:0];
  endfunction

  // Named internal events, also used by the bound checker.
  logic                    restart;
  logic                    word_tick;
  logic                    settled;
  logic                    fast_mode;
  logic signed [ACC_W-1:0] integ_sum;
  logic signed [ACC_W-1:0] comb_sum;
  logic signed [OUT_W-1:0] word_scaled;

  sinc3_ctrl #(
    .N_FAST (DEC_FAST),
    .N_SLOW (DEC_SLOW),
    .SETTLE (ORDER)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .restart   (restart),
    .word_tick (word_tick),
    .settled   (settled),
    .fast_mode (fast_mode)
  );

  sinc3_integ #(
    .ACC_W (ACC_W),
    .ORDER (ORDER)
  ) u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (restart),
    .sample_bit (mod_bit),
    .acc_next   (integ_sum)
  );

  sinc3_comb #(
    .ACC_W (ACC_W),
    .ORDER (ORDER)
  ) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .tick     (word_tick),
    .din      (integ_sum),
    .diff_out (comb_sum)
  );

  assign word_scaled = scale_word(comb_sum, fast_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else if (restart) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= word_tick && settled;
      if (word_tick) dout <= word_scaled;
    end
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
`timescale 1ns/1ps
module sinc3_decim_chk #(
  parameter int DEC_FAST = 16,
  parameter int OUT_W    = 16,
  parameter int SETTLE   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    restart,
  input logic                    word_tick,
  input logic signed [OUT_W-1:0] dout,
  input logic                    dout_valid
);
  localparam int SEEN_W = $clog2(SETTLE + 1);
  localparam int GAP_W  = $clog2(2 * DEC_FAST + 1);
  localparam logic signed [OUT_W-1:0] FULL_SCALE = OUT_W'(1 << (OUT_W - 2));

  logic [SEEN_W-1:0] seen;
  logic [GAP_W-1:0]  gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || restart) begin
      seen <= '0;
      gap  <= '0;
    end else if (word_tick) begin
      if (seen != SEEN_W'(SETTLE)) seen <= seen + 1'b1;
      gap <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(word_tick)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid); // R3
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (seen == SEEN_W'(SETTLE))); // R4
  AST_SETTLED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && !restart && seen >= SEEN_W'(SETTLE - 1)) |=> dout_valid); // R4
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dout == '0 && !dout_valid)); // R5
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(word_tick) && !$past(restart)) |-> $stable(dout)); // R8
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick |-> (gap == GAP_W'(DEC_FAST - 1) || gap == GAP_W'(2 * DEC_FAST - 1))); // R2
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout <= FULL_SCALE && dout >= -FULL_SCALE)); // R7
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .DEC_FAST (DEC_FAST),
  .OUT_W    (OUT_W),
  .SETTLE   (sinc3_pkg::SINC_ORDER)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .word_tick  (word_tick),
  .dout       (dout),
  .dout_valid (dout_valid)
);

// File: tb/sinc3_decim_bench.sv
`timescale 1ns/1ps
module sinc3_decim_bench;
  localparam int NF = 16;
  localparam int NS = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rate_sel = 1'b1;
  logic               mod_bit = 1'b0;
  logic signed [15:0] dout;
  logic               dout_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int n_bits;
  bit cur_rate;
  int last_word;
  int xs [0:4095];
  int h  [0:127];

  always #2.5 clk = ~clk;

  sinc3_decim #(.DEC_FAST(NF), .OUT_W(16)) u_sinc3_decim (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .mod_bit(mod_bit),
    .dout(dout), .dout_valid(dout_valid)
  );

  function automatic int ratio(input bit r);
    return r ? NF : NS;
  endfunction

  // Weights of the cubed box: count of (a,b,c) in [0,N-1]^3 with sum j.
  task automatic build_weights();
    int nn;
    nn = ratio(cur_rate);
    for (int j = 0; j < 128; j++) h[j] = 0;
    for (int a = 0; a < nn; a++)
      for (int b = 0; b < nn; b++)
        for (int c = 0; c < nn; c++) h[a+b+c] = h[a+b+c] + 1;
  endtask

  function automatic int expect_word(input int cnt);
    int nn;
    int s;
    nn = ratio(cur_rate);
    s = 0;
    for (int j = 0; j <= 3*nn - 3; j++)
      if (cnt - 1 - j >= 0) s += h[j] * xs[cnt-1-j];
    if (cur_rate) s = s * 8;
    return s >>> 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic restart_model(input bit r);
    cur_rate  = r;
    n_bits    = 0;
    last_word = 0;
    build_weights();
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks.
  task automatic step(input bit b, input bit r);
    bit rs;
    int nn;
    int k;
    mod_bit  = b;
    rate_sel = r;
    rs = (r != cur_rate);
    @(posedge clk);
    @(negedge clk);
    if (rs) begin
      restart_model(r);
      check(dout_valid == 1'b0, "R5", int'(dout_valid), 0);
      check(dout == 16'sd0, "R5", int'(dout), 0);
    end else begin
      xs[n_bits] = b ? 1 : -1;
      n_bits++;
      nn = ratio(cur_rate);
      if (n_bits % nn == 0) begin
        k = n_bits / nn;
        last_word = expect_word(n_bits);
        check(dout_valid == (k >= 3), (k >= 3) ? "R2" : "R4", int'(dout_valid), int'(k >= 3));
        check(int'(dout) == last_word, "R1", int'(dout), last_word);
      end else begin
        check(dout_valid == 1'b0, "R3", int'(dout_valid), 0);
        check(int'(dout) == last_word, "R8", int'(dout), last_word);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mod_bit = 1'b0;
    repeat (2) @(negedge clk);
    check(dout == 16'sd0, "R6", int'(dout), 0);
    check(dout_valid == 1'b0, "R6", int'(dout_valid), 0);
    rst_n = 1'b1;
    restart_model(1'b1);
  endtask

  task automatic random_run(input bit r, input int nbits, input int dens);
    for (int i = 0; i < nbits; i++) step(($urandom % 16) < dens, r);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();

    // Directed: all-high slow stream reaches positive full scale (R7).
    for (int i = 0; i < 6*NS + 1; i++) step(1'b1, 1'b0);
    check(int'(dout) == 16384, "R7", int'(dout), 16384);

    // Directed: switch to fast, all-low stream reaches negative full scale.
    for (int i = 0; i < 6*NF + 1; i++) step(1'b0, 1'b1);
    check(int'(dout) == -16384, "R7", int'(dout), -16384);

    // Rate change in the middle of a word (R5).
    random_run(1'b1, NF + 5, 8);
    random_run(1'b0, NS + 7, 11);
    random_run(1'b1, 4*NF, 5);

    // Random densities, alternating rates.
    for (int run = 0; run < 8; run++) begin
      bit r;
      r = run[0];
      random_run(r, 7*ratio(r) + int'($urandom % 9), int'($urandom % 17));
    end

    // Reset in the middle of a run, then slow mode from the first edge (R6).
    random_run(1'b0, 20, 9);
    do_reset();
    random_run(1'b0, 5*NS, 12);
    random_run(1'b1, 5*NF, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule